// File: doc/BRIEF.md
# ADC interrupt status controller

This block gathers the completion and timeout events of a four-slot ADC conversion sequencer and turns them into sticky status flags and one interrupt line. Each slot raises a single-cycle pulse on its done input when a conversion finishes and on its timeout input when a conversion overruns. A flag is captured only if its bit in the status-enable register is set. The interrupt line is asserted while any captured flag also has its bit set in the signal-enable register.

Software reaches the three registers through a simple 32-bit write/read port with a byte address. Flags stay set when they are read. To clear flags, software writes the status word back with the bits it wants cleared set to zero; bits written as one keep their value. If a new event lands in the same cycle as a clear, the event wins, so no conversion result is lost between reading the status and clearing it.

Top module: `adc_irq_status_ctrl`

## Requirements
- R1: Reset clears the status-enable register, the signal-enable register and every status flag, and holds `irq_o` low. This holds at power-up and when reset is asserted during operation.
- R2: A pulse on `done_evt_i[k]` sets status bit 8+k on the next clock edge, provided status-enable bit 8+k is set at that edge.
- R3: A pulse on `tout_evt_i[k]` sets status bit 16+k on the next clock edge, provided status-enable bit 16+k is set at that edge.
- R4: An event whose status-enable bit is clear leaves its flag at zero.
- R5: Reading the status register, for any number of cycles, leaves every flag unchanged.
- R6: A write to the status register clears each flag whose data bit is 0 and leaves alone each flag whose data bit is 1.
- R7: When an enabled event and a write of 0 reach the same flag in the same cycle, the flag is 1 afterwards.
- R8: `irq_o` equals the OR, over all flags, of the flag ANDed with its signal-enable bit. A captured flag whose signal-enable bit is clear does not raise `irq_o`.
- R9: Only bits 11:8 and 19:16 are implemented, in all three registers. All other bits read as zero and ignore writes. Writing all ones to an enable register reads back 0x000F0F00.
- R10: The status-enable register is at byte offset 0x0, the signal-enable register at 0x4 and the status register at 0x8. Reads from any other offset return zero, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Byte offset of the accessed register |
| reg_we_i | input | 1 | Write strobe for the addressed register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the addressed register (combinational) |
| done_evt_i | input | 4 | Per-slot conversion-done pulse, slot A at bit 0 |
| tout_evt_i | input | 4 | Per-slot conversion-timeout pulse, slot A at bit 0 |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker watches every cycle for the following:
- flags stay set unless the status register is written;
- a flag stays clear when its status enable is off and nothing sets it;
- every enabled event is captured;
- the interrupt line follows the enabled flags;
- unimplemented status bits read as zero.

Some behaviour can only be shown by the bench's scenarios: the exact write-back-zero clearing pattern, the event-beats-clear collision, the address decode of unused offsets, enable-register read-back masking, and reset in the middle of operation.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;

   // Register selected by the current access address.
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STEN = 2'd1,
      SEL_SIEN = 2'd2,
      SEL_STAT = 2'd3
   } reg_sel_e;

   localparam int unsigned DEF_OFF_STEN = 0;
   localparam int unsigned DEF_OFF_SIEN = 4;
   localparam int unsigned DEF_OFF_STAT = 8;

endpackage

// File: rtl/adc_irq_addr_dec.sv
module adc_irq_addr_dec
   import adc_irq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned OFF_STEN = DEF_OFF_STEN,
   parameter int unsigned OFF_SIEN = DEF_OFF_SIEN,
   parameter int unsigned OFF_STAT = DEF_OFF_STAT
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_e          sel_o
);

   localparam logic [ADDR_W-1:0] A_STEN = ADDR_W'(OFF_STEN);
   localparam logic [ADDR_W-1:0] A_SIEN = ADDR_W'(OFF_SIEN);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

   always_comb begin
      if (addr_i == A_STEN)      sel_o = SEL_STEN;
      else if (addr_i == A_SIEN) sel_o = SEL_SIEN;
      else if (addr_i == A_STAT) sel_o = SEL_STAT;
      else                       sel_o = SEL_NONE;
   end

endmodule

// File: rtl/adc_irq_en_reg.sv
module adc_irq_en_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o <= '0;
      else if (we_i) q_o <= d_i;
   end

endmodule

// File: rtl/adc_irq_flag_bank.sv
module adc_irq_flag_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] evt_i,
   input  logic [W-1:0] arm_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] keep_i,
   output logic [W-1:0] flag_o
);

   for (genvar i = 0; i < W; i++) begin : g_flag
      logic set_now;
      logic hold;
      assign set_now = evt_i[i] & arm_i[i];
      assign hold    = flag_o[i] & (~clr_we_i | keep_i[i]);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) flag_o[i] <= 1'b0;
         else         flag_o[i] <= set_now | hold;
      end
   end

endmodule

// File: rtl/adc_irq_line.sv
module adc_irq_line #(
   parameter int unsigned W       = 8,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] flag_i,
   input  logic [W-1:0] sig_en_i,
   output logic         irq_o
);

   logic any_req;
   assign any_req = |(flag_i & sig_en_i);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_o <= 1'b0;
         else         irq_o <= any_req;
      end
   end else begin : g_comb
      assign irq_o = any_req;
   end

endmodule

// File: rtl/adc_irq_status_ctrl.sv
module adc_irq_status_ctrl
   import adc_irq_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned DONE_LSB  = 8,
   parameter int unsigned TOUT_LSB  = 16,
   parameter int unsigned OFF_STEN  = DEF_OFF_STEN,
   parameter int unsigned OFF_SIEN  = DEF_OFF_SIEN,
   parameter int unsigned OFF_STAT  = DEF_OFF_STAT,
   parameter bit          IRQ_REG   = 1'b0
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [ADDR_W-1:0]    reg_addr_i,
   input  logic                 reg_we_i,
   input  logic [DATA_W-1:0]    reg_wdata_i,
   output logic [DATA_W-1:0]    reg_rdata_o,
   input  logic [NUM_SLOTS-1:0] done_evt_i,
   input  logic [NUM_SLOTS-1:0] tout_evt_i,
   output logic                 irq_o
);

   localparam int unsigned NUM_EVT = 2 * NUM_SLOTS;

   // Elaboration-time parameter checks
   if (DONE_LSB + NUM_SLOTS > DATA_W || TOUT_LSB + NUM_SLOTS > DATA_W) begin : g_bad_fit
      $error("event fields do not fit in the data word");
   end
   if (DONE_LSB < TOUT_LSB + NUM_SLOTS && TOUT_LSB < DONE_LSB + NUM_SLOTS) begin : g_bad_overlap
      $error("done and timeout fields overlap");
   end
   if (OFF_STEN == OFF_SIEN || OFF_STEN == OFF_STAT || OFF_SIEN == OFF_STAT) begin : g_bad_map
      $error("register offsets must be distinct");
   end

   reg_sel_e           sel;
   logic [NUM_EVT-1:0] evt_vec;
   logic [NUM_EVT-1:0] wr_vec;
   logic [NUM_EVT-1:0] sten_q;
   logic [NUM_EVT-1:0] sien_q;
   logic [NUM_EVT-1:0] stat_q;
   logic [DATA_W-1:0]  impl_mask;
   logic               unused_wdata;

   assign evt_vec = {tout_evt_i, done_evt_i};

   // Extract the implemented fields from a bus word
   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_pick
      assign wr_vec[i]           = reg_wdata_i[DONE_LSB+i];
      assign wr_vec[NUM_SLOTS+i] = reg_wdata_i[TOUT_LSB+i];
   end

   always_comb begin
      impl_mask = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         impl_mask[DONE_LSB+i] = 1'b1;
         impl_mask[TOUT_LSB+i] = 1'b1;
      end
   end
   assign unused_wdata = ^(reg_wdata_i & ~impl_mask);

   adc_irq_addr_dec #(
      .ADDR_W  (ADDR_W),
      .OFF_STEN(OFF_STEN),
      .OFF_SIEN(OFF_SIEN),
      .OFF_STAT(OFF_STAT)
   ) dec_i (
      .addr_i(reg_addr_i),
      .sel_o (sel)
   );

   adc_irq_en_reg #(.W(NUM_EVT)) sten_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (reg_we_i && sel == SEL_STEN),
      .d_i   (wr_vec),
      .q_o   (sten_q)
   );

   adc_irq_en_reg #(.W(NUM_EVT)) sien_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (reg_we_i && sel == SEL_SIEN),
      .d_i   (wr_vec),
      .q_o   (sien_q)
   );

   adc_irq_flag_bank #(.W(NUM_EVT)) flags_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt_vec),
      .arm_i   (sten_q),
      .clr_we_i(reg_we_i && sel == SEL_STAT),
      .keep_i  (wr_vec),
      .flag_o  (stat_q)
   );

   adc_irq_line #(.W(NUM_EVT), .REG_OUT(IRQ_REG)) line_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flag_i  (stat_q),
      .sig_en_i(sien_q),
      .irq_o   (irq_o)
   );

   // Read path: place the selected vector back into its bus positions
   logic [NUM_EVT-1:0] rd_vec;
   always_comb begin
      unique case (sel)
         SEL_STEN: rd_vec = sten_q;
         SEL_SIEN: rd_vec = sien_q;
         SEL_STAT: rd_vec = stat_q;
         default:  rd_vec = '0;
      endcase
      reg_rdata_o = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         reg_rdata_o[DONE_LSB+i] = rd_vec[i];
         reg_rdata_o[TOUT_LSB+i] = rd_vec[NUM_SLOTS+i];
      end
   end

endmodule

// File: rtl/adc_irq_status_chk.sv
module adc_irq_status_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned DONE_LSB  = 8,
   parameter int unsigned TOUT_LSB  = 16,
   parameter int unsigned OFF_STAT  = 8,
   parameter bit          IRQ_REG   = 1'b0
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic [ADDR_W-1:0]      reg_addr_i,
   input logic                   reg_we_i,
   input logic [DATA_W-1:0]      reg_rdata_o,
   input logic [2*NUM_SLOTS-1:0] evt_i,
   input logic [2*NUM_SLOTS-1:0] flags_i,
   input logic [2*NUM_SLOTS-1:0] sten_i,
   input logic [2*NUM_SLOTS-1:0] sien_i,
   input logic                   irq_o
);

   localparam int unsigned NUM_EVT = 2 * NUM_SLOTS;

   logic [DATA_W-1:0] impl_mask;
   logic              stat_wr;

   always_comb begin
      impl_mask = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         impl_mask[DONE_LSB+i] = 1'b1;
         impl_mask[TOUT_LSB+i] = 1'b1;
      end
   end
   assign stat_wr = reg_we_i && (reg_addr_i == ADDR_W'(OFF_STAT));

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (flags_i[i] && !stat_wr) |=> flags_i[i]); // R5
      AST_NO_LATCH_DISARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!flags_i[i] && !sten_i[i]) |=> !flags_i[i]); // R4
      AST_EVENT_CAPTURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (evt_i[i] && sten_i[i]) |=> flags_i[i]); // R7
   end

   if (IRQ_REG) begin : g_irq_reg
      AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         irq_o == $past(|(flags_i & sien_i))); // R8
   end else begin : g_irq_comb
      AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         irq_o == |(flags_i & sien_i)); // R8
   end

   AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_addr_i == ADDR_W'(OFF_STAT)) |-> ((reg_rdata_o & ~impl_mask) == '0)); // R9

endmodule

bind adc_irq_status_ctrl adc_irq_status_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .NUM_SLOTS(NUM_SLOTS),
   .DONE_LSB (DONE_LSB),
   .TOUT_LSB (TOUT_LSB),
   .OFF_STAT (OFF_STAT),
   .IRQ_REG  (IRQ_REG)
) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .reg_addr_i (reg_addr_i),
   .reg_we_i   (reg_we_i),
   .reg_rdata_o(reg_rdata_o),
   .evt_i      (evt_vec),
   .flags_i    (stat_q),
   .sten_i     (sten_q),
   .sien_i     (sien_q),
   .irq_o      (irq_o)
);

// File: tb/adc_irq_status_ctrl_tb_top.sv
module adc_irq_status_ctrl_tb_top;

   localparam logic [3:0] A_STEN = 4'h0;
   localparam logic [3:0] A_SIEN = 4'h4;
   localparam logic [3:0] A_STAT = 4'h8;
   localparam logic [3:0] A_BAD  = 4'hC;

   // {status-enable, signal-enable, events {tout,done}, expected flags, expected irq}
   localparam int NVEC = 8;
   localparam logic [32:0] VEC [NVEC] = '{
      {8'hFF, 8'hFF, 8'h01, 8'h01, 1'b1},
      {8'hFF, 8'h00, 8'h04, 8'h04, 1'b0},
      {8'h0F, 8'hFF, 8'h30, 8'h00, 1'b0},
      {8'hF0, 8'h80, 8'h82, 8'h80, 1'b1},
      {8'hAA, 8'h55, 8'hFF, 8'hAA, 1'b0},
      {8'h33, 8'h22, 8'hA5, 8'h21, 1'b1},
      {8'h00, 8'hFF, 8'hFF, 8'h00, 1'b0},
      {8'hFF, 8'h10, 8'h18, 8'h18, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  done = '0;
   logic [3:0]  tout = '0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   adc_irq_status_ctrl dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .reg_addr_i (addr),
      .reg_we_i   (we),
      .reg_wdata_i(wdata),
      .reg_rdata_o(rdata),
      .done_evt_i (done),
      .tout_evt_i (tout),
      .irq_o      (irq)
   );

   // Compact {tout,done} byte to bus word: done at 11:8, timeout at 19:16
   function automatic logic [31:0] w(input logic [7:0] v);
      return {12'h0, v[7:4], 4'h0, v[3:0], 8'h0};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; we = 1'b1; wdata = d;
      @(negedge clk);
      we = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic pulse(input logic [7:0] ev);
      @(negedge clk);
      done = ev[3:0]; tout = ev[7:4];
      @(negedge clk);
      done = '0; tout = '0;
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got %08h expected %08h", 32'h0, 32'h1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 irq after reset", {31'h0, irq}, 32'h0);
      rst_n = 1'b1;
      rd(A_STEN, r); chk("R1 status-enable reset", r, 32'h0);
      rd(A_SIEN, r); chk("R1 signal-enable reset", r, 32'h0);
      rd(A_STAT, r); chk("R1 status reset", r, 32'h0);

      // Vector table: R2 R3 R4 R8
      for (int k = 0; k < NVEC; k++) begin
         wr(A_STEN, w(VEC[k][32:25]));
         wr(A_SIEN, w(VEC[k][24:17]));
         wr(A_STAT, 32'h0);
         pulse(VEC[k][16:9]);
         #1;
         chk($sformatf("R8 irq vector %0d", k), {31'h0, irq}, {31'h0, VEC[k][0]});
         rd(A_STAT, r);
         chk($sformatf("R2 R3 R4 flags vector %0d", k), r, w(VEC[k][8:1]));
      end

      // R6 write-zero clears, write-one keeps
      wr(A_STEN, 32'hFFFF_FFFF);
      wr(A_SIEN, 32'h0);
      wr(A_STAT, 32'h0);
      pulse(8'h0F);
      wr(A_STAT, 32'hFFFF_FDFF);
      rd(A_STAT, r); chk("R6 clear bit 9 only", r, 32'h0000_0D00);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, r); chk("R6 write ones keeps", r, 32'h0000_0D00);

      // R5 repeated reads leave status unchanged
      for (int k = 0; k < 3; k++) begin
         rd(A_STAT, r); chk("R5 read is non-destructive", r, 32'h0000_0D00);
      end

      // R8 signal enable gates the line
      #1 chk("R8 no irq without signal enable", {31'h0, irq}, 32'h0);
      wr(A_SIEN, w(8'h04));
      #1 chk("R8 irq on enabling bit 10", {31'h0, irq}, 32'h1);
      wr(A_STAT, 32'hFFFF_FBFF);
      #1 chk("R8 irq drops after clear", {31'h0, irq}, 32'h0);

      // R7 event beats clear in the same cycle
      wr(A_SIEN, 32'h0);
      wr(A_STAT, 32'h0);
      pulse(8'h03);
      @(negedge clk);
      addr = A_STAT; we = 1'b1; wdata = 32'h0; done = 4'h5;
      @(negedge clk);
      we = 1'b0; done = '0;
      rd(A_STAT, r); chk("R7 event wins over clear", r, 32'h0000_0500);

      // R9 reserved bits
      rd(A_STEN, r); chk("R9 enable read-back masked", r, 32'h000F_0F00);
      wr(A_STAT, 32'h0);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, r); chk("R9 writing ones sets nothing", r, 32'h0);

      // R10 unused offset
      wr(A_BAD, 32'h0);
      rd(A_STEN, r); chk("R10 write to unused offset ignored", r, 32'h000F_0F00);
      rd(A_BAD, r);  chk("R10 unused offset reads zero", r, 32'h0);

      // R1 reset during operation
      wr(A_SIEN, 32'hFFFF_FFFF);
      pulse(8'h81);
      #1 chk("R8 irq before mid reset", {31'h0, irq}, 32'h1);
      @(negedge clk); rst_n = 1'b0;
      #1 chk("R1 irq low in reset", {31'h0, irq}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      rd(A_STAT, r); chk("R1 status cleared mid-run", r, 32'h0);
      rd(A_STEN, r); chk("R1 status-enable cleared mid-run", r, 32'h0);
      rd(A_SIEN, r); chk("R1 signal-enable cleared mid-run", r, 32'h0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule